// File: doc/BRIEF.md
# Per-Port Detection Control Register Bank

This block sits between a register bus and four per-port detection and classification engines of a powered-device detection controller. It holds two control registers and one reserved location. The enable register carries one detection-enable and one classification-enable bit per port. The cadence register carries one back-off enable bit per port. For each port the block turns these bits into single-cycle start pulses toward the engines. It also consumes the engines' done and pass/fail results.

The meaning of an enable bit depends on the operating mode input. In automatic and semiautomatic mode a set bit is a standing order: detection is restarted after every result, and classification follows a passed detection. In manual mode a written 1 is a one-shot request that clears itself when its cycle finishes. In shutdown mode writes to the enable register are dropped and nothing is started. After a failed detection, a port with cadence enabled waits a parameterized number of clock cycles (nominally 2 s) before it detects again. Reset values come from two strap inputs, which are sampled while reset is held.

Top module: `pse_detect_regs`

## Requirements
- R1: While reset is held, the enable register (offset BASE_ADDR, default 0x14) loads 0xFF if the auto strap is 1 and 0x00 if it is 0. Bits [3:0] enable detection on ports 1..4 and bits [7:4] enable classification on ports 1..4. Port 1 is the lowest bit of each nibble.
- R2: While reset is held, the cadence register (offset BASE_ADDR+1) loads the midspan strap into each of bits [3:0] and 0 into bits [7:4]. Bits [7:4] always read 0 and ignore writes.
- R3: rd_data shows the register at the address pointer, and ptr_ld loads that pointer. Each wr_en or rd_en strobe advances the pointer by one. This includes a strobe at the reserved offset BASE_ADDR+2, which always reads 0x00 and whose writes change no register.
- R4: mode_i encodes 00 = shutdown, 01 = manual, 10 = semiautomatic and 11 = automatic. In modes 10 and 11 an idle port whose detection bit is set raises det_start. After each det_done it raises det_start again in the next cycle unless a back-off is running.
- R5: In modes 10 and 11, a det_done with det_pass=1 on a port whose classification bit is set raises cls_start in the following cycle. After a failed detection, no cls_start is issued.
- R6: In mode 01 a write can only set enable bits, and each set bit launches exactly one cycle. Detection has priority over classification. The bit stays set while its cycle runs and reads 0 from the cycle after the matching done pulse. A detection launched in this mode never chains into classification.
- R7: In mode 01, writing a 1 again to a bit whose cycle is running causes no extra start pulse. The bit still clears on the done pulse of the running cycle.
- R8: In mode 00, writes to the enable register leave it unchanged and no start pulse is issued.
- R9: A failed detection on a port with cadence enabled holds off that port's next det_start by exactly CAD_CYCLES additional clock cycles. With cadence disabled, det_start follows in the next cycle.
- R10: Start pulses last one cycle. A port never has more than one detection or classification request outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the straps are sampled while it is low |
| mode_i | input | 2 | Operating mode (00 shutdown, 01 manual, 10 semiautomatic, 11 automatic) |
| auto_strap | input | 1 | Strap that selects the enable register reset value |
| midspan_strap | input | 1 | Strap that gives the cadence bits their reset value |
| ptr_ld | input | 1 | Load the address pointer from ptr_addr |
| ptr_addr | input | ADDR_W | New address pointer value |
| wr_en | input | 1 | Write wr_data at the pointer, then advance it |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; advances the pointer |
| rd_data | output | 8 | Contents of the register at the pointer |
| det_start | output | N_PORTS | Per-port detection start pulse |
| cls_start | output | N_PORTS | Per-port classification start pulse |
| det_done | input | N_PORTS | Per-port detection finished pulse |
| det_pass | input | N_PORTS | Detection result, valid with det_done |
| cls_done | input | N_PORTS | Per-port classification finished pulse |

## Verification
A port sequencer stuck in a wrong state shows up at the start outputs within one cycle of the next done pulse: a missing or doubled pulse, or a classification start after a failed detection. A wrong back-off count moves the restart of detection by exactly the error, so it is measured to the cycle against CAD_CYCLES. A wrong clear or merge of the enable bits is visible on the next register read as a bit that is still set or that cleared too early. A wrong pointer step shows up on the read that follows the strobe.

// File: rtl/pse_ctl_pkg.sv
package pse_ctl_pkg;
  typedef enum logic [1:0] {
    MODE_SHDN   = 2'b00,
    MODE_MANUAL = 2'b01,
    MODE_SEMI   = 2'b10,
    MODE_AUTO   = 2'b11
  } op_mode_e;

  typedef enum logic [1:0] {
    PS_IDLE = 2'b00,
    PS_DET  = 2'b01,
    PS_CLQ  = 2'b10,
    PS_CLS  = 2'b11
  } port_st_e;
endpackage

// File: rtl/pse_bus_ptr.sv
module pse_bus_ptr #(
  parameter int ADDR_W = 8,
  parameter int DW = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_ld,
  input  logic [ADDR_W-1:0] ptr_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DW-1:0]     en_q,
  input  logic [DW-1:0]     cad_q,
  output logic              en_we,
  output logic              cad_we,
  output logic [DW-1:0]     rd_data
);
  localparam logic [ADDR_W-1:0] EN_A  = BASE_ADDR;
  localparam logic [ADDR_W-1:0] CAD_A = BASE_ADDR + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] RSV_A = BASE_ADDR + ADDR_W'(2);

  logic [ADDR_W-1:0] ptr_q;
  logic              bus_acc;

  function automatic logic [ADDR_W-1:0] ptr_step(input logic [ADDR_W-1:0] cur,
                                                 input logic ld,
                                                 input logic [ADDR_W-1:0] ldv,
                                                 input logic acc);
    if (ld) return ldv;
    if (acc) return cur + ADDR_W'(1);
    return cur;
  endfunction

  function automatic logic [DW-1:0] read_mux(input logic [ADDR_W-1:0] a,
                                             input logic [DW-1:0] en,
                                             input logic [DW-1:0] cad);
    if (a == EN_A) return en;
    if (a == CAD_A) return cad;
    return '0;
  endfunction

  assign bus_acc = wr_en | rd_en;
  assign en_we   = wr_en & ~ptr_ld & (ptr_q == EN_A);
  assign cad_we  = wr_en & ~ptr_ld & (ptr_q == CAD_A);
  assign rd_data = read_mux(ptr_q, en_q, cad_q);

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= EN_A;
    else        ptr_q <= ptr_step(ptr_q, ptr_ld, ptr_in, bus_acc);
  end

  a_r3_reserved_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == RSV_A) |-> (rd_data == '0));

  a_r3_autoinc: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_acc && !ptr_ld) |=> (ptr_q == ADDR_W'($past(ptr_q) + ADDR_W'(1))));
endmodule

// File: rtl/pse_ctl_regs.sv
module pse_ctl_regs
  import pse_ctl_pkg::*;
#(
  parameter int N_PORTS = 4,
  localparam int DW = 2 * N_PORTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_strap,
  input  logic              mid_strap,
  input  op_mode_e          mode,
  input  logic              en_we,
  input  logic              cad_we,
  input  logic [DW-1:0]     wd,
  input  logic [N_PORTS-1:0] det_clr,
  input  logic [N_PORTS-1:0] cls_clr,
  output logic [DW-1:0]     en_q,
  output logic [DW-1:0]     cad_q
);
  logic [DW-1:0] clr;
  assign clr = {cls_clr, det_clr};

  function automatic logic [DW-1:0] en_merge(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] d,
                                             input logic we,
                                             input op_mode_e m,
                                             input logic [DW-1:0] c);
    logic [DW-1:0] v;
    v = cur;
    if (we && m != MODE_SHDN) v = (m == MODE_MANUAL) ? (cur | d) : d;
    return v & ~c;
  endfunction

  function automatic logic [DW-1:0] cad_mask(input logic [DW-1:0] d);
    return {{N_PORTS{1'b0}}, d[N_PORTS-1:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= {DW{auto_strap}};
      cad_q <= cad_mask({DW{mid_strap}});
    end else begin
      en_q <= en_merge(en_q, wd, en_we, mode, clr);
      if (cad_we) cad_q <= cad_mask(wd);
    end
  end

  a_r6_clear_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((en_q & $past(clr)) == '0));

  a_r8_shdn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SHDN && clr == '0) |=> $stable(en_q));

  a_r2_cad_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cad_q[DW-1:N_PORTS] == '0);
endmodule

// File: rtl/pse_port_seq.sv
module pse_port_seq
  import pse_ctl_pkg::*;
#(
  parameter int CAD_CYCLES = 500_000_000,
  localparam int CAD_W = $clog2(CAD_CYCLES + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  op_mode_e mode,
  input  logic     det_en,
  input  logic     cls_en,
  input  logic     cad_en,
  input  logic     det_done,
  input  logic     det_pass,
  input  logic     cls_done,
  output logic     det_start,
  output logic     cls_start,
  output logic     det_clr,
  output logic     cls_clr,
  output logic     backoff
);
  port_st_e        st_q;
  logic [CAD_W-1:0] cnt_q;
  logic            man_q;
  logic            manual, running, idle;
  logic            want_det, want_cls_man, cad_load;

  assign manual   = (mode == MODE_MANUAL);
  assign running  = (mode == MODE_AUTO) || (mode == MODE_SEMI);
  assign idle     = (st_q == PS_IDLE);
  assign backoff  = (cnt_q != '0);

  assign want_det     = idle && !backoff && det_en && (running || manual);
  assign want_cls_man = idle && manual && cls_en && !det_en;
  assign cad_load     = (st_q == PS_DET) && det_done && !det_pass && cad_en;

  assign det_start = want_det;
  assign cls_start = ((st_q == PS_CLQ) && mode != MODE_SHDN) || want_cls_man;
  assign det_clr   = (st_q == PS_DET) && det_done && man_q;
  assign cls_clr   = (st_q == PS_CLS) && cls_done && man_q;

  function automatic logic [CAD_W-1:0] cad_next(input logic [CAD_W-1:0] cur,
                                                input logic load);
    if (load) return CAD_W'(CAD_CYCLES);
    if (cur != '0) return cur - CAD_W'(1);
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      man_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cad_next(cnt_q, cad_load);
      unique case (st_q)
        PS_IDLE: begin
          if (want_det) begin
            st_q  <= PS_DET;
            man_q <= manual;
          end else if (want_cls_man) begin
            st_q  <= PS_CLS;
            man_q <= 1'b1;
          end
        end
        PS_DET: if (det_done)
          st_q <= (det_pass && cls_en && !man_q) ? PS_CLQ : PS_IDLE;
        PS_CLQ: st_q <= (mode == MODE_SHDN) ? PS_IDLE : PS_CLS;
        PS_CLS: if (cls_done) st_q <= PS_IDLE;
        default: st_q <= PS_IDLE;
      endcase
    end
  end

  a_r10_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    (det_start || cls_start) |=> (!det_start && !cls_start));

  a_r10_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(det_start && cls_start));

  a_r8_shdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SHDN) |-> (!det_start && !cls_start));

  a_r9_backoff_hold: assert property (@(posedge clk) disable iff (!rst_n)
    backoff |-> !det_start);
endmodule

// File: rtl/pse_detect_regs.sv
module pse_detect_regs
  import pse_ctl_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h14,
  parameter int CAD_CYCLES = 500_000_000,
  localparam int DW = 2 * N_PORTS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic               auto_strap,
  input  logic               midspan_strap,
  input  logic               ptr_ld,
  input  logic [ADDR_W-1:0]  ptr_addr,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_en,
  output logic [DW-1:0]      rd_data,
  output logic [N_PORTS-1:0] det_start,
  output logic [N_PORTS-1:0] cls_start,
  input  logic [N_PORTS-1:0] det_done,
  input  logic [N_PORTS-1:0] det_pass,
  input  logic [N_PORTS-1:0] cls_done
);
  op_mode_e          mode;
  logic              en_we, cad_we;
  logic [DW-1:0]     en_q, cad_q;
  logic [N_PORTS-1:0] det_clr, cls_clr, backoff;

  assign mode = op_mode_e'(mode_i);

  pse_bus_ptr #(.ADDR_W(ADDR_W), .DW(DW), .BASE_ADDR(BASE_ADDR)) u_bus (
    .clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .ptr_in(ptr_addr),
    .wr_en(wr_en), .rd_en(rd_en), .en_q(en_q), .cad_q(cad_q),
    .en_we(en_we), .cad_we(cad_we), .rd_data(rd_data)
  );

  pse_ctl_regs #(.N_PORTS(N_PORTS)) u_regs (
    .clk(clk), .rst_n(rst_n), .auto_strap(auto_strap), .mid_strap(midspan_strap),
    .mode(mode), .en_we(en_we), .cad_we(cad_we), .wd(wr_data),
    .det_clr(det_clr), .cls_clr(cls_clr), .en_q(en_q), .cad_q(cad_q)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    pse_port_seq #(.CAD_CYCLES(CAD_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .det_en(en_q[p]), .cls_en(en_q[N_PORTS + p]), .cad_en(cad_q[p]),
      .det_done(det_done[p]), .det_pass(det_pass[p]), .cls_done(cls_done[p]),
      .det_start(det_start[p]), .cls_start(cls_start[p]),
      .det_clr(det_clr[p]), .cls_clr(cls_clr[p]), .backoff(backoff[p])
    );
  end

  a_r4_no_start_while_backoff: assert property (@(posedge clk) disable iff (!rst_n)
    (det_start & backoff) == '0);
endmodule

// File: tb/pse_detect_regs_tb.sv
`timescale 1ns/1ps
module pse_detect_regs_tb;
  localparam int NP = 4;
  localparam int CADC = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       auto_strap = 1'b1, midspan_strap = 1'b1;
  logic       ptr_ld = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] ptr_addr = 8'h00, wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [NP-1:0] det_start, cls_start;
  logic [NP-1:0] det_done = '0, det_pass = '0, cls_done = '0;

  int total = 0, bad = 0, cyc = 0;
  int det_cnt [NP];
  int cls_cnt [NP];

  always #2 clk = ~clk;

  pse_detect_regs #(.N_PORTS(NP), .ADDR_W(8), .BASE_ADDR(8'h14), .CAD_CYCLES(CADC)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .auto_strap(auto_strap),
    .midspan_strap(midspan_strap), .ptr_ld(ptr_ld), .ptr_addr(ptr_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .det_start(det_start), .cls_start(cls_start), .det_done(det_done),
    .det_pass(det_pass), .cls_done(cls_done)
  );

  initial for (int i = 0; i < NP; i++) begin det_cnt[i] = 0; cls_cnt[i] = 0; end

  always @(posedge clk) if (rst_n)
    for (int i = 0; i < NP; i++) begin
      if (det_start[i]) det_cnt[i]++;
      if (cls_start[i]) cls_cnt[i]++;
    end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); ptr_ld = 1'b1; ptr_addr = a;
    @(negedge clk); ptr_ld = 1'b0; wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); ptr_ld = 1'b1; ptr_addr = a;
    @(negedge clk); ptr_ld = 1'b0; d = rd_data;
  endtask

  task automatic pulse_det(input int p, input logic pass);
    @(negedge clk); det_done[p] = 1'b1; det_pass[p] = pass;
    @(negedge clk); det_done[p] = 1'b0; det_pass[p] = 1'b0;
  endtask

  task automatic do_reset(input logic a, input logic m);
    @(negedge clk); rst_n = 1'b0; auto_strap = a; midspan_strap = m; mode_i = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_defaults;
    logic [7:0] v;
    do_reset(1'b1, 1'b1);
    read_reg(8'h14, v); chk("R1 enable reset auto=1", v, 8'hFF);
    read_reg(8'h15, v); chk("R2 cadence reset midspan=1", v, 8'h0F);
    do_reset(1'b0, 1'b0);
    read_reg(8'h14, v); chk("R1 enable reset auto=0", v, 8'h00);
    read_reg(8'h15, v); chk("R2 cadence reset midspan=0", v, 8'h00);
    do_reset(1'b1, 1'b1);
  endtask

  task automatic t_shdn;
    logic [7:0] v;
    write_reg(8'h14, 8'h00);
    read_reg(8'h14, v); chk("R8 shutdown write ignored", v, 8'hFF);
    repeat (4) @(negedge clk);
    chk("R8 no start in shutdown", det_cnt[0] + det_cnt[1] + det_cnt[2] + det_cnt[3]
        + cls_cnt[0] + cls_cnt[1] + cls_cnt[2] + cls_cnt[3], 0);
  endtask

  task automatic t_reserved;
    logic [7:0] v;
    write_reg(8'h16, 8'hAB);
    read_reg(8'h16, v); chk("R3 reserved reads zero", v, 8'h00);
    read_reg(8'h15, v); chk("R3 reserved write left cadence", v, 8'h0F);
    @(negedge clk); ptr_ld = 1'b1; ptr_addr = 8'h14;
    @(negedge clk); ptr_ld = 1'b0; chk("R3 pointer at enable", rd_data, 8'hFF); rd_en = 1'b1;
    @(negedge clk); chk("R3 autoinc to cadence", rd_data, 8'h0F);
    @(negedge clk); chk("R3 autoinc to reserved", rd_data, 8'h00);
    @(negedge clk); rd_en = 1'b0; chk("R3 autoinc past reserved", rd_data, 8'h00);
    write_reg(8'h15, 8'hF5);
    read_reg(8'h15, v); chk("R2 cadence high bits ignore write", v, 8'h05);
  endtask

  task automatic t_auto;
    logic [7:0] v;
    do_reset(1'b0, 1'b0);
    @(negedge clk); mode_i = 2'b11;
    write_reg(8'h14, 8'h01);
    chk("R4 det_start after enable", det_start, 4'b0001);
    @(negedge clk); chk("R10 start is one cycle", det_start, 4'b0000);
    repeat (3) @(negedge clk);
    chk("R10 one outstanding request", det_cnt[0], 1);
    pulse_det(0, 1'b0);
    chk("R4 restart after done", det_start, 4'b0001);
    chk("R9 no cadence restarts next cycle", det_cnt[0], 1);
    @(negedge clk);
    chk("R4 restart counted once", det_cnt[0], 2);
  endtask

  task automatic t_cadence;
    int n;
    write_reg(8'h15, 8'h01);
    @(negedge clk); det_done[0] = 1'b1;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); det_done[0] = 1'b0; n++;
      if (det_start[0]) break;
    end
    chk("R9 back-off delay in cycles", n, CADC + 1);
  endtask

  task automatic t_class;
    write_reg(8'h15, 8'h00);
    write_reg(8'h14, 8'h11);
    pulse_det(0, 1'b1);
    chk("R5 cls_start after pass", cls_start, 4'b0001);
    chk("R5 no det_start with cls_start", det_start, 4'b0000);
    @(negedge clk); cls_done[0] = 1'b1;
    @(negedge clk); cls_done[0] = 1'b0;
    chk("R4 detection resumes after class", det_start, 4'b0001);
    begin
      int c0;
      c0 = cls_cnt[0];
      pulse_det(0, 1'b0);
      @(negedge clk);
      chk("R5 no class after fail", cls_cnt[0], c0);
    end
  endtask

  task automatic t_manual;
    logic [7:0] v;
    int d1;
    write_reg(8'h14, 8'h00);
    pulse_det(0, 1'b0);
    @(negedge clk); mode_i = 2'b01;
    d1 = det_cnt[1];
    write_reg(8'h14, 8'h02);
    chk("R6 manual launch", det_start, 4'b0010);
    read_reg(8'h14, v); chk("R6 bit held while running", v, 8'h02);
    write_reg(8'h14, 8'h02);
    write_reg(8'h14, 8'h00);
    read_reg(8'h14, v); chk("R7 rewrite and zero write ignored", v, 8'h02);
    chk("R7 no extra start", det_cnt[1], d1 + 1);
    pulse_det(1, 1'b1);
    read_reg(8'h14, v); chk("R6 bit clears after done", v, 8'h00);
    repeat (4) @(negedge clk);
    chk("R6 single cycle launched", det_cnt[1], d1 + 1);
    chk("R6 no chain to class in manual", cls_cnt[1], 0);
    write_reg(8'h14, 8'h40);
    chk("R6 manual class launch", cls_start, 4'b0100);
    @(negedge clk); cls_done[2] = 1'b1;
    @(negedge clk); cls_done[2] = 1'b0;
    read_reg(8'h14, v); chk("R6 class bit clears", v, 8'h00);
    chk("R6 class launched once", cls_cnt[2], 1);
  endtask

  initial begin
    t_reset_defaults();
    t_shdn();
    t_reserved();
    t_auto();
    t_cadence();
    t_class();
    t_manual();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule